// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a set of register copies, organised as groups of instances, that all answer at one bus address. A selector register picks which copy a bus access reaches. It holds a group number, an instance number and a broadcast flag. A write with the flag set reaches every copy. A write with the flag clear reaches only the selected copy. A read always returns only the selected copy, whatever the flag says. A second replicated register, called the pinned register, has the same write rules, but its reads always go to one fixed copy and ignore the selector.

Each copy has a presence bit, which is its fuse and its power state combined. Accesses that reach an absent copy are terminated. Reads from an absent copy return zero. Writes to an absent copy are dropped without any error. Software first programs the selector and then reads or writes the shared address.

Top module: `repl_steer_bank`

## Requirements
- R1: After reset the selector has the broadcast flag set and group and instance both 0. Every copy holds 0 and rdata is 0.
- R2: A write to word address 0 loads the selector. The instance comes from wdata[1:0], the group from wdata[9:8] and the broadcast flag from wdata[16]. Reading address 0 returns these fields in the same positions, with all other bits 0.
- R3: A write to address 1 or 2 with the broadcast flag set stores wdata in every present copy of that register. Absent copies keep their old value.
- R4: A write to address 1 or 2 with the broadcast flag clear stores wdata only in copy group*4+instance. All other copies are unchanged.
- R5: A write with the broadcast flag clear that is steered to an absent copy changes no copy.
- R6: A read of address 1 returns copy group*4+instance, whether the broadcast flag is set or clear.
- R7: A read of address 1 that is steered to an absent copy returns 0.
- R8: A read of address 2 always returns copy 1 (group 0, instance 1), whatever the selector holds. It returns 0 when that copy is absent.
- R9: rdata takes the read result at the clock edge that samples rd_en, so it is valid one cycle after the request. rdata holds its value on cycles without a read.
- R10: Reads of addresses other than 0, 1 and 2 return 0. Writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| present | input | 16 | Per-copy presence (fuse and power-on), bit g*4+i |

## Verification
The hardest case to reach is a broadcast write, or a steered write, that lands while some copies are absent. The effect only becomes visible later, after the selector has been moved to each affected copy and that copy is present again, so that a read can show the old value that survived. The stimulus therefore changes the presence mask at random between operations and keeps it sparse at times. Random selector writes scatter the steering across all copies. Directed sequences write with holes in the mask, then restore full presence and walk the selector over every copy.

// File: rtl/repl_steer_bank.sv
module repl_steer_bank #(
  parameter int NGRP     = 4,
  parameter int NINST    = 4,
  parameter int DW       = 32,
  parameter int AW       = 4,
  parameter int SEL_ADDR = 0,
  parameter int REP_ADDR = 1,
  parameter int PIN_ADDR = 2,
  parameter int PIN_GRP  = 0,
  parameter int PIN_INST = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic [NGRP*NINST-1:0]  present
);
  localparam int GW      = (NGRP  > 1) ? $clog2(NGRP)  : 1;
  localparam int IW      = (NINST > 1) ? $clog2(NINST) : 1;
  localparam int NCOPY   = NGRP * NINST;
  localparam int CW      = GW + IW;
  localparam int GRP_LSB = 8;
  localparam int MC_BIT  = 16;
  localparam int PIN_IDX = PIN_GRP * NINST + PIN_INST;

  logic [GW-1:0] sel_g;
  logic [IW-1:0] sel_i;
  logic          sel_mc;
  logic [NCOPY-1:0][DW-1:0] rep_q;
  logic [NCOPY-1:0][DW-1:0] pin_q;

  wire [CW-1:0] idx     = {sel_g, sel_i};
  wire          hit_sel = (addr == AW'(SEL_ADDR));
  wire          hit_rep = (addr == AW'(REP_ADDR));
  wire          hit_pin = (addr == AW'(PIN_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_g  <= '0;
      sel_i  <= '0;
      sel_mc <= 1'b1;
    end else if (wr_en && hit_sel) begin
      sel_i  <= wdata[IW-1:0];
      sel_g  <= wdata[GRP_LSB +: GW];
      sel_mc <= wdata[MC_BIT];
    end
  end

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    wire take = wr_en && present[c] && (sel_mc || idx == CW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rep_q[c] <= '0;
        pin_q[c] <= '0;
      end else begin
        if (take && hit_rep) rep_q[c] <= wdata;
        if (take && hit_pin) pin_q[c] <= wdata;
      end
    end
  end

  logic [DW-1:0] sel_word, rd_mux;
  always_comb begin
    sel_word = '0;
    sel_word[IW-1:0]        = sel_i;
    sel_word[GRP_LSB +: GW] = sel_g;
    sel_word[MC_BIT]        = sel_mc;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_sel)      rd_mux = sel_word;
    else if (hit_rep) rd_mux = present[idx] ? rep_q[idx] : '0;
    else if (hit_pin) rd_mux = present[PIN_IDX] ? pin_q[PIN_IDX] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

module repl_steer_bank_chk #(
  parameter int NCOPY = 16,
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int CW    = 4,
  parameter int PIN_IDX = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      addr,
  input logic               wr_en,
  input logic               rd_en,
  input logic [DW-1:0]      rdata,
  input logic [NCOPY-1:0]   present,
  input logic [CW-1:0]      idx,
  input logic               sel_mc,
  input logic [NCOPY*DW-1:0] rep_flat
);
  AST_SEL_RESET: assert property (@(posedge clk)
    !rst_n |=> (sel_mc && idx == '0));  // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));  // R9

  AST_ABSENT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(1) && !present[idx]) |=> rdata == '0);  // R7

  AST_PIN_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(2) && !present[PIN_IDX]) |=> rdata == '0);  // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > AW'(2)) |=> rdata == '0);  // R10

  AST_ABSENT_UNICAST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1) && !sel_mc && !present[idx])
      |=> $stable(rep_flat));  // R5
endmodule

bind repl_steer_bank repl_steer_bank_chk #(
  .NCOPY(NCOPY), .DW(DW), .AW(AW), .CW(CW), .PIN_IDX(PIN_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .present(present), .idx(idx), .sel_mc(sel_mc),
  .rep_flat(rep_q)
);

// File: tb/tb_repl_steer_bank.sv
module tb_repl_steer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] present = 16'hFFFF;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_rep [16];
  logic [31:0] m_pin [16];
  logic [1:0]  m_g = 0, m_i = 0;
  logic        m_mc = 1;

  always #4 clk = ~clk;

  repl_steer_bank dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .present(present));

  function automatic logic [31:0] sel_word();
    return {15'd0, m_mc, 6'd0, m_g, 6'd0, m_i};
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    int k = {m_g, m_i};
    if (a == 0) return sel_word();
    if (a == 1) return present[k] ? m_rep[k] : 32'd0;
    if (a == 2) return present[1] ? m_pin[1] : 32'd0;
    return 32'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    int k = {m_g, m_i};
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    if (a == 0) begin m_i = d[1:0]; m_g = d[9:8]; m_mc = d[16]; end
    else if (a == 1 || a == 2)
      for (int c = 0; c < 16; c++)
        if (present[c] && (m_mc || c == k)) begin
          if (a == 1) m_rep[c] = d; else m_pin[c] = d;
        end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    e = exp_read(a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rdata, e);
  endtask

  task automatic steer(input int g, input int i, input bit mc);
    wr(0, {15'd0, mc, 6'd0, 2'(g), 6'd0, 2'(i)});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    for (int c = 0; c < 16; c++) begin m_rep[c] = 0; m_pin[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk("R1 rdata", rdata, 32'd0);
    rd(0, "R1 selector reset");
    rd(1, "R1 copy0 reset");

    steer(2, 3, 0);
    rd(0, "R2 selector readback");
    wr(0, 32'hFFFE_FCFC);
    rd(0, "R2 reserved bits zero");

    steer(0, 0, 1);
    present = 16'hFFFF;
    wr(1, 32'hAAAA_0000);
    for (int c = 0; c < 16; c++) begin steer(c / 4, c % 4, 1); rd(1, "R3 bcast all"); end

    steer(1, 2, 0);
    wr(1, 32'h1234_5678);
    for (int c = 0; c < 16; c++) begin steer(c / 4, c % 4, 0); rd(1, "R4 unicast only target"); end

    present = 16'hFFFF & ~16'h0420;
    steer(0, 0, 1);
    wr(1, 32'hBEEF_0001);
    steer(1, 1, 0);
    rd(1, "R7 absent read zero");
    wr(1, 32'hDEAD_0005);
    present = 16'hFFFF;
    rd(1, "R5 dropped unicast");
    steer(2, 2, 1);
    rd(1, "R3 absent kept old");
    steer(3, 3, 1);
    rd(1, "R6 read with bcast flag set");

    steer(3, 2, 0);
    wr(2, 32'h5555_AAAA);
    steer(0, 1, 0);
    wr(2, 32'h0F0F_0F0F);
    steer(3, 2, 1);
    rd(2, "R8 pinned ignores selector");
    present[1] = 1'b0;
    rd(2, "R8 pinned absent zero");
    present[1] = 1'b1;

    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, "R10 unmapped read");
    rd(0, "R10 selector untouched");
    rd(1, "R10 copy untouched");

    rd(1, "R9 read result");
    held = rdata;
    wr(1, 32'h7777_7777);
    repeat (3) @(negedge clk);
    chk("R9 hold without read", rdata, held);

    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      if ($urandom_range(0, 7) == 0)
        present = ($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'($urandom);
      case (op)
        0, 1: wr(0, $urandom);
        2, 3: wr(1, $urandom);
        4:    wr(2, $urandom);
        5:    wr(4'($urandom_range(3, 15)), $urandom);
        default: begin
          logic [3:0] a = 4'($urandom_range(0, 4));
          case (a)
            0: rd(a, "R2 random");
            1: rd(a, present[{m_g, m_i}] ? "R6 random" : "R7 random");
            2: rd(a, "R8 random");
            default: rd(a, "R10 random");
          endcase
        end
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule